// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the command front end of a byte-wide parallel NOR flash model. It sees each host write as a single-cycle strobe with an address and a data byte. It matches those strobes against a fixed set of unlock and command sequences. When a sequence completes, it raises a one-cycle request to the operation engine. The requests are byte program, sector erase, chip erase, boot-block lockout enable, and identification-mode entry or exit. It also holds the identification-mode flag. While that flag is set, it supplies the identification byte for the read address, and the surrounding read path selects that byte instead of array data.

Sequence matching uses only address bits 10..0. Bit 11 and everything above it are don't-care, except for the target address of a program and the sector address of a sector erase, which are passed on whole. While the engine reports busy, every write is dropped and the decoder returns to its idle point. A write that breaks a sequence also returns it to idle. The one exception is a data byte of 0xF0, which is always read as an identification exit.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all request outputs are 0, `id_mode` is 0 and `id_data` is 0x00.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then D@A raise `req_prog` for exactly one cycle, in the cycle after the fourth write, with `req_addr`=A and `req_data`=D.
- R3: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x10@0x555 raise `req_chip_erase` for one cycle after the sixth write.
- R4: The same five-write prefix as R3, followed by 0x30 written to any address S, raises `req_sect_erase` for one cycle with `req_addr`=S.
- R5: The same five-write prefix as R3, followed by 0x40@0x555, raises `req_lock` for one cycle.
- R6: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 raise `req_id_enter` for one cycle and set `id_mode` to 1 in that same cycle.
- R7: Either of two forms raises `req_id_exit` for one cycle and clears `id_mode`: a write of 0xF0 to any address that is not consumed by a sequence step, or 0xAA@0x555, 0x55@0x2AA, 0xF0@0x555.
- R8: Sequence matching compares only address bits 10..0. Addresses 0xAAA and 0x2AA are equivalent, and bits above 11 are ignored.
- R9: A write that does not match the next expected step returns the decoder to idle and raises no request. A correct sequence that follows is then accepted.
- R10: A write made while `busy` is 1 raises no request, and the decoder is idle afterwards. This holds even when the write would have completed a sequence.
- R11: While `id_mode` is 1, `id_data` is selected by `rd_addr[1:0]`: 0 gives 0x1F, 1 gives 0x07, 2 gives {7'b0, `lock_in`} (bit 0 set means locked), and 3 gives 0x0F.
- R12: At most one request output is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle sampled write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Operation engine busy |
| lock_in | input | 1 | Current boot-block lockout flag |
| rd_addr | input | ADDR_W | Read address |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification byte for `rd_addr` |
| req_prog | output | 1 | Byte program request |
| req_sect_erase | output | 1 | Sector erase request |
| req_chip_erase | output | 1 | Chip erase request |
| req_lock | output | 1 | Lockout enable request |
| req_id_enter | output | 1 | Identification entry request |
| req_id_exit | output | 1 | Identification exit request |
| req_addr | output | ADDR_W | Target or sector address |
| req_data | output | 8 | Program data byte |

## Verification
Two things can fall in the same cycle: `busy` being high and the write that completes a sequence. The bench provokes this by raising `busy` exactly on the fourth program write and on the sixth erase write. It judges the outcome by the absence of any request pulse. It then issues a lone data write to confirm that the decoder fell back to idle rather than waiting on the final step. A second collision, `busy` arriving in the middle of an unlock pair, is judged the same way: the rest of that sequence must produce nothing.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          ADDR_W = 18,
  parameter logic [7:0]  MFG_ID = 8'h1F,
  parameter logic [7:0]  DEV_ID = 8'h07,
  parameter logic [7:0]  EXT_ID = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              lock_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_mode,
  output logic [7:0]        id_data,
  output logic              req_prog,
  output logic              req_sect_erase,
  output logic              req_chip_erase,
  output logic              req_lock,
  output logic              req_id_enter,
  output logic              req_id_exit,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5} st_t;

  st_t        st, nxt;
  logic [5:0] req_nxt, req_q;

  wire at_555 = wr_addr[10:0] == 11'h555;
  wire at_2aa = wr_addr[10:0] == 11'h2AA;
  wire is_f0  = wr_data == 8'hF0;

  // req bit order: prog, sect, chip, lock, enter, exit
  always_comb begin
    nxt     = S_IDLE;
    req_nxt = '0;
    unique case (st)
      S_IDLE: if (at_555 && wr_data == 8'hAA) nxt = S_U1;
              else if (is_f0) req_nxt[0] = 1'b1;
      S_U1:   if (at_2aa && wr_data == 8'h55) nxt = S_U2;
              else if (is_f0) req_nxt[0] = 1'b1;
      S_U2: begin
        if (at_555 && wr_data == 8'hA0)      nxt = S_PGM;
        else if (at_555 && wr_data == 8'h80) nxt = S_E3;
        else if (at_555 && wr_data == 8'h90) req_nxt[1] = 1'b1;
        else if (is_f0)                      req_nxt[0] = 1'b1;
      end
      S_PGM:  req_nxt[5] = 1'b1;
      S_E3:   if (at_555 && wr_data == 8'hAA) nxt = S_E4;
              else if (is_f0) req_nxt[0] = 1'b1;
      S_E4:   if (at_2aa && wr_data == 8'h55) nxt = S_E5;
              else if (is_f0) req_nxt[0] = 1'b1;
      S_E5: begin
        if (wr_data == 8'h30)                req_nxt[4] = 1'b1;
        else if (at_555 && wr_data == 8'h10) req_nxt[3] = 1'b1;
        else if (at_555 && wr_data == 8'h40) req_nxt[2] = 1'b1;
        else if (is_f0)                      req_nxt[0] = 1'b1;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      req_q    <= '0;
      id_mode  <= 1'b0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      req_q <= '0;
      if (busy) begin
        st <= S_IDLE;
      end else if (wr_en) begin
        st       <= nxt;
        req_q    <= req_nxt;
        req_addr <= wr_addr;
        req_data <= wr_data;
        if (req_nxt[1])      id_mode <= 1'b1;
        else if (req_nxt[0]) id_mode <= 1'b0;
      end
    end
  end

  assign {req_prog, req_sect_erase, req_chip_erase, req_lock, req_id_enter, req_id_exit} = req_q;

  always_comb begin
    id_data = 8'h00;
    if (id_mode)
      unique case (rd_addr[1:0])
        2'd0: id_data = MFG_ID;
        2'd1: id_data = DEV_ID;
        2'd2: id_data = {7'b0, lock_in};
        2'd3: id_data = EXT_ID;
        default: id_data = 8'h00;
      endcase
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              id_mode,
  input logic              req_prog,
  input logic              req_sect_erase,
  input logic              req_chip_erase,
  input logic              req_lock,
  input logic              req_id_enter,
  input logic              req_id_exit,
  input logic [7:0]        req_data
);
  wire [5:0] reqs = {req_prog, req_sect_erase, req_chip_erase, req_lock, req_id_enter, req_id_exit};

  a_r12_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs));

  a_r6_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    req_id_enter |-> id_mode);

  a_r7_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    req_id_exit |-> !id_mode);

  a_r10_busy_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (reqs == 6'b0));

  a_r2_prog_data: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |-> ($past(wr_en) && req_data == $past(wr_data)));

  a_r4_sector_code: assert property (@(posedge clk) disable iff (!rst_n)
    req_sect_erase |-> ($past(wr_en) && $past(wr_data) == 8'h30));

  a_r9_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reqs != 6'b0) |-> $past(wr_en && !busy));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .id_mode(id_mode), .req_prog(req_prog), .req_sect_erase(req_sect_erase),
  .req_chip_erase(req_chip_erase), .req_lock(req_lock), .req_id_enter(req_id_enter),
  .req_id_exit(req_id_exit), .req_data(req_data)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int ADDR_W = 18;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              wr_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              busy = 0;
  logic              lock_in = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              id_mode;
  logic [7:0]        id_data;
  logic              req_prog, req_sect_erase, req_chip_erase, req_lock, req_id_enter, req_id_exit;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_data;

  int checks = 0;
  int fails  = 0;
  logic [5:0] got;

  // request vector order: prog, sect, chip, lock, enter, exit
  localparam logic [5:0] NONE = 6'b000000, PRG = 6'b100000, SEC = 6'b010000,
                         CHP = 6'b001000, LCK = 6'b000100, ENT = 6'b000010, EXT = 6'b000001;

  flash_cmd_decoder #(.ADDR_W(ADDR_W)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .lock_in(lock_in), .rd_addr(rd_addr), .id_mode(id_mode), .id_data(id_data),
    .req_prog(req_prog), .req_sect_erase(req_sect_erase), .req_chip_erase(req_chip_erase),
    .req_lock(req_lock), .req_id_enter(req_id_enter), .req_id_exit(req_id_exit),
    .req_addr(req_addr), .req_data(req_data));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write; got = request vector visible in the cycle after
  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d, logic b = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_en = 0; busy = 0;
    got = {req_prog, req_sect_erase, req_chip_erase, req_lock, req_id_enter, req_id_exit};
  endtask

  task automatic unlock(logic [ADDR_W-1:0] hi = '0);
    wr(hi | 18'h555, 8'hAA); chk("R9 silent unlock", got, NONE);
    wr(hi | 18'h2AA, 8'h55); chk("R9 silent unlock", got, NONE);
  endtask

  task automatic t_reset();
    chk("R1 requests", {req_prog, req_sect_erase, req_chip_erase, req_lock, req_id_enter, req_id_exit}, NONE);
    chk("R1 id_mode", id_mode, 0);
    chk("R1 id_data", id_data, 8'h00);
  endtask

  task automatic t_program();
    unlock();
    wr(18'h00555, 8'hA0); chk("R2 step3", got, NONE);
    wr(18'h1ABCD, 8'h5A); chk("R2 request", got, PRG);
    chk("R2 addr", req_addr, 18'h1ABCD);
    chk("R2 data", req_data, 8'h5A);
    @(negedge clk);
    chk("R2 one cycle", req_prog, 0);
  endtask

  task automatic t_erase_prefix(logic [ADDR_W-1:0] hi = '0);
    unlock(hi);
    wr(hi | 18'h555, 8'h80); chk("R3 step3", got, NONE);
    unlock(hi);
  endtask

  task automatic t_chip();
    t_erase_prefix();
    wr(18'h00555, 8'h10); chk("R3 chip erase", got, CHP);
  endtask

  task automatic t_sector();
    t_erase_prefix();
    wr(18'h2C123, 8'h30); chk("R4 sector erase", got, SEC);
    chk("R4 sector addr", req_addr, 18'h2C123);
  endtask

  task automatic t_lock();
    t_erase_prefix();
    wr(18'h00555, 8'h40); chk("R5 lock", got, LCK);
  endtask

  task automatic t_bit11();
    // R8: upper bits and bit 11 set on every step (0xAAA style)
    t_erase_prefix(18'h3F800);
    wr(18'h3FD55, 8'h10); chk("R8 aliased chip erase", got, CHP);
    unlock(18'h00800);
    wr(18'h00D55, 8'hA0);
    wr(18'h00042, 8'h11); chk("R8 aliased program", got, PRG);
  endtask

  task automatic t_id();
    unlock();
    wr(18'h00555, 8'h90); chk("R6 enter", got, ENT);
    chk("R6 id_mode", id_mode, 1);
    lock_in = 0;
    rd_addr = 18'h0; #1 chk("R11 mfg", id_data, 8'h1F);
    rd_addr = 18'h1; #1 chk("R11 dev", id_data, 8'h07);
    rd_addr = 18'h2; #1 chk("R11 unlocked", id_data, 8'h00);
    lock_in = 1;     #1 chk("R11 locked", id_data, 8'h01);
    rd_addr = 18'h3; #1 chk("R11 ext", id_data, 8'h0F);
    wr(18'h3FFFF, 8'hF0); chk("R7 single exit", got, EXT);
    chk("R7 id_mode cleared", id_mode, 0);
    chk("R7 id_data off", id_data, 8'h00);
    unlock(); wr(18'h00555, 8'h90);
    unlock(); wr(18'h00555, 8'hF0); chk("R7 long exit", got, EXT);
    chk("R7 long exit mode", id_mode, 0);
    unlock(); wr(18'h00555, 8'h90);
    wr(18'h00555, 8'hAA);
    wr(18'h00123, 8'hF0); chk("R7 mismatched F0 exit", got, EXT);
    chk("R7 mismatched F0 mode", id_mode, 0);
  endtask

  task automatic t_mismatch();
    wr(18'h00555, 8'hAA);
    wr(18'h00554, 8'h55); chk("R9 bad address", got, NONE);
    wr(18'h00555, 8'hA0); chk("R9 no stray step", got, NONE);
    wr(18'h00100, 8'h77); chk("R9 no program", got, NONE);
    t_erase_prefix();
    wr(18'h00555, 8'h20); chk("R9 bad final code", got, NONE);
    t_program();
  endtask

  task automatic t_busy();
    unlock(); wr(18'h00555, 8'hA0);
    wr(18'h00200, 8'h33, 1); chk("R10 program dropped", got, NONE);
    wr(18'h00200, 8'h44);    chk("R10 idle after drop", got, NONE);
    t_erase_prefix();
    wr(18'h00555, 8'h10, 1); chk("R10 chip erase dropped", got, NONE);
    wr(18'h00555, 8'hAA);
    wr(18'h002AA, 8'h55, 1);
    wr(18'h00555, 8'hA0);
    wr(18'h00300, 8'h66);    chk("R10 mid-unlock busy", got, NONE);
    wr(18'h00000, 8'hF0, 1); chk("R10 exit dropped", got, NONE);
  endtask

  initial begin
    fork
      begin
        #5;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_program();
        t_chip();
        t_sector();
        t_lock();
        t_bit11();
        t_id();
        t_mismatch();
        t_busy();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule